// File: doc/BRIEF.md
# Buffered Serial Receive Queue

This block is the receive half of a FIFO-buffered asynchronous serial port. A deserializer hands it one character at a time with a valid strobe, and the block stores the character in a 16-entry first-in first-out queue. Software drains the queue through a small 16-bit register bus. The same bus is used to program the queue and to read its flags.

Two thresholds are programmed through a control register, and each is picked from a fixed table. The first is the receive trigger. At or above it the block raises a receive-full flag, and below it the block raises data-ready whenever any character is waiting. The second is the acceptance limit. It drives a ready-to-accept output that the line side uses for flow control.

When a character arrives with the queue already full, it is dropped and an overrun bit is recorded in a separate line-status register. Reading that register returns its value and clears it.

Top module: `rxq_top`

## Requirements
- R1: The queue stores up to 16 characters and returns them on data-register reads (address 3, character in bits [7:0]) in arrival order.
- R2: A character that arrives while 16 are stored and no read is taken in the same cycle is dropped, and it sets bit 0 of the line-status register (address 2). The stored characters are left unchanged.
- R3: A read of the line-status register returns its value and clears it to zero. A write loads bit 0 from the write data. An overrun in the same cycle takes priority over both.
- R4: Control bits [8:7] (address 0) select the receive trigger T: 0→1, 1→4, 2→8, 3→14.
- R5: After every character stored or removed, the status register (address 1) is re-evaluated. Bit 1 (receive-full) is set when the count is at least T. Bit 0 (data-ready) is set when the count is below T and above zero. A control write alone does not re-evaluate them.
- R6: Control bits [11:9] select the acceptance limit L: 0→15, 1→1, 2→4, 3→6, 4→8, 5→10, 6→12, 7→14. The `rx_ready` output is high only while the count is below L.
- R7: The status register reads 0x0060 after reset, with bits 6 and 5 always set. Bits 0 and 1 are zero while the queue is empty after a reset or a clear.
- R8: A data-register read on an empty queue returns 0 and changes no state.
- R9: If a character arrives in the same cycle as a data-register read, the count is unchanged and the order is kept. This also holds when the queue is full, and in that case no overrun occurs.
- R10: While control bit 1 is set, the queue is held empty and both receive flags are cleared. Characters arriving during that time are dropped without an overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Character strobe from the deserializer |
| rx_data | input | 8 | Received character |
| bus_addr | input | 2 | Register select: 0 control, 1 status, 2 line status, 3 data |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effects at the clock edge) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid combinationally during the read cycle |
| rx_ready | output | 1 | Ready to accept more characters (flow control) |
| data_ready | output | 1 | Data-ready flag, status bit 0 |
| rx_full | output | 1 | Receive-full flag, status bit 1 |

## Verification
The assertions assume that the bus never raises write and read in the same cycle. They also assume that software holds the control clear bit for at least one full cycle before it expects the queue to be empty. The bench drives exactly one bus strobe per transaction and clears the queue with two back-to-back control writes, so it stays within both assumptions. The deserializer may still push a character while `rx_ready` is low; the bench does this on purpose to reach the full queue and overrun cases.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_STAT = 2'd1,
    REG_LINE = 2'd2,
    REG_DATA = 2'd3
  } rxq_reg_e;

  localparam int CTRL_CLR_BIT  = 1;
  localparam int CTRL_TRIG_LSB = 7;
  localparam int CTRL_ACC_LSB  = 9;
  localparam logic [15:0] CTRL_MASK = 16'h0F82;
  localparam logic [15:0] STAT_FIXED = 16'h0060;
  localparam int STAT_DR_BIT   = 0;
  localparam int STAT_FULL_BIT = 1;

  function automatic int unsigned trig_level(input logic [1:0] sel);
    case (sel)
      2'd0:    return 1;
      2'd1:    return 4;
      2'd2:    return 8;
      default: return 14;
    endcase
  endfunction

  function automatic int unsigned accept_limit(input logic [2:0] sel);
    if (sel == 3'd0) return 15;
    if (sel == 3'd1) return 1;
    return 2 * int'(sel);
  endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              push_req,
  input  logic              pop_req,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] head,
  output logic              push_ok,
  output logic              pop_ok,
  output logic              ovf,
  output logic [CNT_W-1:0]  cnt_q,
  output logic [CNT_W-1:0]  cnt_next
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_q, wr_d, rd_q, rd_d;
  logic              full, empty;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full  = (cnt_q == CNT_W'(DEPTH));
  assign empty = (cnt_q == '0);

  always_comb begin
    pop_ok  = pop_req && !empty && !clr;
    push_ok = push_req && !clr && (!full || pop_ok);
    ovf     = push_req && !clr && full && !pop_ok;
  end

  always_comb begin
    wr_d     = wr_q;
    rd_d     = rd_q;
    cnt_next = cnt_q;
    if (clr) begin
      wr_d     = '0;
      rd_d     = '0;
      cnt_next = '0;
    end else begin
      if (push_ok) wr_d = bump(wr_q);
      if (pop_ok)  rd_d = bump(rd_q);
      if (push_ok && !pop_ok) cnt_next = cnt_q + 1'b1;
      if (pop_ok && !push_ok) cnt_next = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_next;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_q] <= din;
  end

  assign head = empty ? '0 : mem[rd_q];

endmodule

// File: rtl/rxq_flags.sv
module rxq_flags
  import rxq_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             update,
  input  logic [1:0]       trig_sel,
  input  logic [2:0]       acc_sel,
  input  logic [CNT_W-1:0] cnt_q,
  input  logic [CNT_W-1:0] cnt_next,
  output logic             dr_q,
  output logic             full_q,
  output logic             ready
);

  logic [CNT_W-1:0] trig_v, lim_v;
  logic             dr_d, full_d;

  assign trig_v = CNT_W'(trig_level(trig_sel));
  assign lim_v  = CNT_W'(accept_limit(acc_sel));

  always_comb begin
    dr_d   = dr_q;
    full_d = full_q;
    if (update) begin
      full_d = (cnt_next >= trig_v);
      dr_d   = (cnt_next < trig_v) && (cnt_next != '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dr_q   <= 1'b0;
      full_q <= 1'b0;
    end else begin
      dr_q   <= dr_d;
      full_q <= full_d;
    end
  end

  assign ready = (cnt_q < lim_v);

endmodule

// File: rtl/rxq_regs.sv
module rxq_regs
  import rxq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int BUS_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BUS_W-1:0]  bus_wdata,
  input  logic              ovf,
  input  logic              dr,
  input  logic              full,
  input  logic [DATA_W-1:0] head,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic [BUS_W-1:0]  ctrl_q,
  output logic              line_q,
  output logic              pop_req
);

  rxq_reg_e         sel;
  logic [BUS_W-1:0] ctrl_d;
  logic             line_d;
  logic             ctrl_en;

  assign sel     = rxq_reg_e'(bus_addr);
  assign pop_req = bus_rd && (sel == REG_DATA);
  assign ctrl_en = bus_wr && (sel == REG_CTRL);
  assign ctrl_d  = bus_wdata & BUS_W'(CTRL_MASK);

  always_comb begin
    line_d = line_q;
    if (ovf)                                 line_d = 1'b1;
    else if (bus_wr && (sel == REG_LINE))    line_d = bus_wdata[0];
    else if (bus_rd && (sel == REG_LINE))    line_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      line_q <= 1'b0;
    end else begin
      if (ctrl_en) ctrl_q <= ctrl_d;
      line_q <= line_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (sel)
      REG_CTRL: bus_rdata = ctrl_q;
      REG_STAT: begin
        bus_rdata                = BUS_W'(STAT_FIXED);
        bus_rdata[STAT_DR_BIT]   = dr;
        bus_rdata[STAT_FULL_BIT] = full;
      end
      REG_LINE: bus_rdata = BUS_W'(line_q);
      default:  bus_rdata = BUS_W'(head);
    endcase
  end

endmodule

// File: rtl/rxq_top.sv
module rxq_top
  import rxq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  parameter int BUS_W  = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic [1:0]        bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              rx_ready,
  output logic              data_ready,
  output logic              rx_full
);

  logic [BUS_W-1:0]  ctrl_q;
  logic              line_q;
  logic              pop_req, push_ok, pop_ok, ovf, clr;
  logic [DATA_W-1:0] head;
  logic [CNT_W-1:0]  cnt_q, cnt_next;

  assign clr = ctrl_q[CTRL_CLR_BIT];

  rxq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .push_req(rx_valid), .pop_req(pop_req), .din(rx_data),
    .head(head), .push_ok(push_ok), .pop_ok(pop_ok), .ovf(ovf),
    .cnt_q(cnt_q), .cnt_next(cnt_next)
  );

  rxq_flags #(.CNT_W(CNT_W)) u_flags (
    .clk(clk), .rst_n(rst_n),
    .update(push_ok || pop_ok || clr),
    .trig_sel(ctrl_q[CTRL_TRIG_LSB +: 2]),
    .acc_sel(ctrl_q[CTRL_ACC_LSB +: 3]),
    .cnt_q(cnt_q), .cnt_next(cnt_next),
    .dr_q(data_ready), .full_q(rx_full), .ready(rx_ready)
  );

  rxq_regs #(.DATA_W(DATA_W), .BUS_W(BUS_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .ovf(ovf), .dr(data_ready), .full(rx_full),
    .head(head), .bus_rdata(bus_rdata), .ctrl_q(ctrl_q),
    .line_q(line_q), .pop_req(pop_req)
  );

endmodule

// File: rtl/rxq_chk.sv
module rxq_chk #(
  parameter int DEPTH = 16,
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_valid,
  input logic [1:0]       bus_addr,
  input logic             bus_wr,
  input logic             bus_rd,
  input logic [15:0]      bus_rdata,
  input logic             rx_ready,
  input logic             data_ready,
  input logic             rx_full,
  input logic             clr,
  input logic             line_q,
  input logic [CNT_W-1:0] cnt_q
);

  assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));

  assert_overrun_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !clr && cnt_q == CNT_W'(DEPTH) && !(bus_rd && bus_addr == 2'd3))
    |=> line_q);

  assert_line_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 2'd2 && !(rx_valid && cnt_q == CNT_W'(DEPTH)))
    |=> !line_q);

  assert_flags_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(data_ready && rx_full));

  assert_ready_room_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |-> (cnt_q < CNT_W'(DEPTH)));

  assert_empty_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 2'd3 && cnt_q == '0) |-> (bus_rdata == 16'h0000));

  assert_pushpop_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && bus_rd && bus_addr == 2'd3 && cnt_q != '0 && !clr)
    |=> $stable(cnt_q));

  assert_clear_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0 && !data_ready && !rx_full));

endmodule

bind rxq_top rxq_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .bus_addr(bus_addr),
  .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
  .rx_ready(rx_ready), .data_ready(data_ready), .rx_full(rx_full),
  .clr(clr), .line_q(line_q), .cnt_q(cnt_q)
);

// File: tb/sim_rxq_top.sv
module sim_rxq_top;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n, rx_valid, bus_wr, bus_rd;
  logic [7:0]  rx_data;
  logic [1:0]  bus_addr;
  logic [15:0] bus_wdata, bus_rdata;
  logic        rx_ready, data_ready, rx_full;

  int checks = 0;
  int errors = 0;

  rxq_top u0 (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_ready(rx_ready),
    .data_ready(data_ready), .rx_full(rx_full)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic int trig_of(input int s);
    case (s) 0: return 1; 1: return 4; 2: return 8; default: return 14; endcase
  endfunction

  function automatic int lim_of(input int s);
    return (s == 0) ? 15 : (s == 1) ? 1 : 2 * s;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic push(input logic [7:0] d);
    rx_valid = 1'b1; rx_data = d;
    cyc();
    rx_valid = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    cyc();
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    cyc();
    bus_rd = 1'b0;
  endtask

  task automatic set_ctrl(input int ts, input int as);
    wr(2'd0, 16'((ts << 7) | (as << 9) | 2));
    wr(2'd0, 16'((ts << 7) | (as << 9)));
  endtask

  task automatic check_stat(input int n, input int t, input string req);
    logic [15:0] v;
    int exp;
    exp = 16'h0060 | ((n >= t) ? 2 : 0) | ((n > 0 && n < t) ? 1 : 0);
    rd(2'd1, v);
    check(v == 16'(exp), req, v, exp);
    check(data_ready == exp[0] && rx_full == exp[1], req, {rx_full, data_ready}, exp & 3);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual 0x0 expected 0x1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v;
    rst_n = 1'b0; rx_valid = 1'b0; rx_data = '0; bus_wr = 1'b0; bus_rd = 1'b0;
    bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R7: reset state
    rd(2'd1, v);
    check(v == 16'h0060, "R7 status after reset", v, 16'h0060);
    check(!data_ready && !rx_full, "R7 flags after reset", {rx_full, data_ready}, 0);
    rd(2'd2, v);
    check(v == 16'h0000, "R3 line status after reset", v, 0);

    // R8: read on empty queue
    rd(2'd3, v);
    check(v == 16'h0000, "R8 empty data read", v, 0);
    check_stat(0, 1, "R8 status unchanged after empty read");

    // R4 R5 R1: trigger sweep with fill and drain
    for (int ts = 0; ts < 4; ts++) begin
      set_ctrl(ts, 0);
      check_stat(0, trig_of(ts), "R10 flags cleared by clear");
      for (int n = 1; n <= 16; n++) begin
        push(8'((ts << 5) + n));
        check_stat(n, trig_of(ts), "R4 R5 flags after push");
      end
      for (int k = 1; k <= 16; k++) begin
        rd(2'd3, v);
        check(v == 16'((ts << 5) + k), "R1 order on drain", v, (ts << 5) + k);
        check_stat(16 - k, trig_of(ts), "R5 flags after pop");
      end
    end

    // R6: acceptance limit sweep
    for (int as = 0; as < 8; as++) begin
      set_ctrl(0, as);
      for (int n = 0; n <= 16; n++) begin
        check(rx_ready == (n < lim_of(as)), "R6 ready vs count", rx_ready, n < lim_of(as));
        if (n < 16) push(8'(n));
      end
    end

    // R2 R3: overrun on full queue, then read-clear
    set_ctrl(3, 0);
    for (int n = 0; n < 16; n++) push(8'h10 + 8'(n));
    push(8'h55);
    rd(2'd2, v);
    check(v == 16'h0001, "R2 overrun recorded", v, 1);
    rd(2'd2, v);
    check(v == 16'h0000, "R3 line cleared by read", v, 0);

    // R9: push and pop together at full
    rx_valid = 1'b1; rx_data = 8'h77;
    rd(2'd3, v);
    rx_valid = 1'b0;
    check(v == 16'h0010, "R9 pop during push returns oldest", v, 16'h10);
    rd(2'd2, v);
    check(v == 16'h0000, "R9 no overrun on push with pop", v, 0);
    check_stat(16, 14, "R9 count kept at full");
    for (int k = 1; k < 16; k++) begin
      rd(2'd3, v);
      check(v == 16'h0010 + 16'(k), "R2 stored data unchanged by overrun", v, 16'h10 + k);
    end
    rd(2'd3, v);
    check(v == 16'h0077, "R9 order kept after simultaneous push", v, 16'h77);
    rd(2'd3, v);
    check(v == 16'h0000, "R8 empty after drain", v, 0);

    // R3: software write of line status
    wr(2'd2, 16'h0001);
    rd(2'd2, v);
    check(v == 16'h0001, "R3 line write loads", v, 1);
    rd(2'd2, v);
    check(v == 16'h0000, "R3 line clears after read", v, 0);

    // R5: control write alone does not re-evaluate flags
    set_ctrl(0, 0);
    for (int n = 0; n < 3; n++) push(8'(n));
    check_stat(3, 1, "R5 full at trigger 1");
    wr(2'd0, 16'(3 << 7));
    check_stat(3, 1, "R5 flags held over control write");
    push(8'h03);
    check_stat(4, 14, "R5 flags re-evaluated on push");

    // R10: arrivals during clear are dropped, no overrun
    wr(2'd0, 16'h0002);
    push(8'hAA);
    push(8'hBB);
    wr(2'd0, 16'h0000);
    rd(2'd3, v);
    check(v == 16'h0000, "R10 queue empty after clear", v, 0);
    rd(2'd2, v);
    check(v == 16'h0000, "R10 no overrun during clear", v, 0);
    check_stat(0, 1, "R10 flags clear after clear");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule